// File: doc/BRIEF.md
# Keyed clock-gate request controller

This block holds the clock-run requests for a group of processing engines and turns them into one clock-enable line per engine. Software writes a 32-bit word whose top nibble is a key. Two key values make the write an atomic set or an atomic clear of the chosen request bits. Any other key makes it an ordinary overwrite. With the set and clear keys, a driver can change the request of one engine without a read-modify-write race against another driver.

A second register picks, for each engine, how gating happens. In direct mode the clock enable simply follows the request bit. In handshake mode the controller first raises an idle request toward the engine and gates the clock only after the engine acknowledges. On an un-gate it turns the clock back on at once, withdraws the idle request, and waits for the acknowledge to drop before it will start another gate sequence. A third, read-only register reports which engine clocks are running now.

Top module: `cg_req_ctrl`

## Requirements
- R1: After synchronous reset, every request bit, configuration bit, clock enable and idle request is 0, and reads of register 0, 1 and 2 return zero.
- R2: A write to register 0 whose key field [31:28] is 0x5 sets each request bit whose data bit in [4:0] is 1 and leaves the bits whose data bit is 0 unchanged.
- R3: A write to register 0 with key 0x2 clears each request bit whose data bit in [4:0] is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: A write to register 0 with any other key loads bits [4:0] into the request register. A request bit of 1 asks for that engine's clock to run, and 0 asks for it to be gated.
- R5: Reads are combinational on the address. Register 0 returns the request bits, register 1 the configuration bits, register 2 the current clock enables, each in [4:0]. Bits [31:5] and all of register 3 read as zero.
- R6: A write to register 1 loads bits [4:0] into the configuration register whatever the key. Bit i = 1 selects the handshake protocol for engine i, and 0 selects direct gating.
- R7: In direct mode, an engine's clock enable takes the value of its request bit one cycle after the request bit changes, and its idle request stays 0.
- R8: In handshake mode, a request bit falling to 0 raises the idle request one cycle later while the clock stays enabled. The clock enable drops on the cycle after idle_ack is seen high, and the idle request stays high while the engine is gated.
- R9: In handshake mode, a request bit rising to 1 enables the clock and drops the idle request one cycle later. A new gate sequence does not start until idle_ack has been seen low.
- R10: Register contents do not change on a cycle without a valid write to them, including writes to registers 2 and 3 and read transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 2 | Register select: 0 request, 1 configuration, 2 status, 3 reserved |
| reg_wdata | input | 32 | Write data; key in [31:28], engine bits in [4:0] |
| reg_rdata | output | 32 | Read data for the selected register |
| idle_ack | input | 5 | Idle acknowledge, one per engine |
| clk_en | output | 5 | Clock enable, one per engine |
| idle_req | output | 5 | Idle request, one per engine |

## Verification
A fault in the key decoder shows in the register 0 readback in the cycle right after the write. A wrong set or clear mask therefore shows at once, as a bit that changed or failed to change. A sequencer that is in the wrong state shows on clk_en or idle_req within one cycle of a request change or an acknowledge edge. The most telling case is a clock that drops before idle_ack, or stays on after it, and this can only be seen in handshake mode. A stuck status path shows up as a difference between clk_en and the register 2 readback.

// File: rtl/cg_req_pkg.sv
package cg_req_pkg;

    localparam int REG_ADDR_W = 2;
    localparam int KEY_W      = 4;

    localparam logic [KEY_W-1:0] KEY_SET = 4'h5;
    localparam logic [KEY_W-1:0] KEY_CLR = 4'h2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_REQ  = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_RSV  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_PLAIN,
        OP_SET,
        OP_CLR
    } wr_op_e;

    typedef enum logic [2:0] {
        GS_OFF,    // gated, no handshake pending
        GS_ON,     // clock running
        GS_DRAIN,  // clock running, waiting for idle acknowledge
        GS_PARK,   // gated after acknowledge
        GS_WAKE    // clock running, waiting for acknowledge to fall
    } gate_st_e;

    typedef struct packed {
        logic en;
        logic idle;
    } gate_out_t;

    function automatic wr_op_e key_to_op(input logic [KEY_W-1:0] key);
        if (key == KEY_SET)      return OP_SET;
        else if (key == KEY_CLR) return OP_CLR;
        else                     return OP_PLAIN;
    endfunction

    function automatic gate_out_t gate_outputs(input gate_st_e st);
        gate_out_t o;
        unique case (st)
            GS_OFF:   o = '{en: 1'b0, idle: 1'b0};
            GS_ON:    o = '{en: 1'b1, idle: 1'b0};
            GS_DRAIN: o = '{en: 1'b1, idle: 1'b1};
            GS_PARK:  o = '{en: 1'b0, idle: 1'b1};
            GS_WAKE:  o = '{en: 1'b1, idle: 1'b0};
            default:  o = '{en: 1'b0, idle: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/cg_key_merge.sv
module cg_key_merge
    import cg_req_pkg::*;
#(
    parameter int N_ENG = 5
) (
    input  logic [KEY_W-1:0] key,
    input  logic [N_ENG-1:0] wbits,
    input  logic [N_ENG-1:0] cur,
    output logic [N_ENG-1:0] nxt
);
    wr_op_e op;

    always_comb begin
        op = key_to_op(key);
        unique case (op)
            OP_SET:  nxt = cur | wbits;
            OP_CLR:  nxt = cur & ~wbits;
            default: nxt = wbits;
        endcase
    end
endmodule

// File: rtl/cg_gate_seq.sv
module cg_gate_seq
    import cg_req_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_req,
    input  logic hs_mode,
    input  logic ack,
    output logic en,
    output logic idle
);
    gate_st_e  st_q, st_d;
    gate_out_t outs;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_OFF:   if (run_req) st_d = GS_ON;
            GS_ON:    if (!run_req) st_d = hs_mode ? GS_DRAIN : GS_OFF;
            GS_DRAIN: begin
                if (run_req)  st_d = GS_WAKE;
                else if (ack) st_d = GS_PARK;
            end
            GS_PARK:  if (run_req) st_d = GS_WAKE;
            GS_WAKE: begin
                if (!ack) begin
                    if (run_req)      st_d = GS_ON;
                    else if (hs_mode) st_d = GS_DRAIN;
                    else              st_d = GS_OFF;
                end
            end
            default:  st_d = GS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= GS_OFF;
        else     st_q <= st_d;
    end

    always_comb begin
        outs = gate_outputs(st_q);
        en   = outs.en;
        idle = outs.idle;
    end
endmodule

// File: rtl/cg_rd_mux.sv
module cg_rd_mux
    import cg_req_pkg::*;
#(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [N_ENG-1:0]      req_bits,
    input  logic [N_ENG-1:0]      cfg_bits,
    input  logic [N_ENG-1:0]      stat_bits,
    output logic [DATA_W-1:0]     rdata
);
    localparam int PAD_W = DATA_W - N_ENG;

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_REQ:  rdata = {{PAD_W{1'b0}}, req_bits};
            SEL_CFG:  rdata = {{PAD_W{1'b0}}, cfg_bits};
            SEL_STAT: rdata = {{PAD_W{1'b0}}, stat_bits};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cg_req_ctrl.sv
module cg_req_ctrl
    import cg_req_pkg::*;
#(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [N_ENG-1:0]      idle_ack,
    output logic [N_ENG-1:0]      clk_en,
    output logic [N_ENG-1:0]      idle_req
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    logic [N_ENG-1:0] req_q, req_d;
    logic [N_ENG-1:0] cfg_q;
    logic             wr_req, wr_cfg;

    assign wr_req = reg_valid && reg_write && (reg_sel_e'(reg_addr) == SEL_REQ);
    assign wr_cfg = reg_valid && reg_write && (reg_sel_e'(reg_addr) == SEL_CFG);

    cg_key_merge #(.N_ENG(N_ENG)) merge_i (
        .key   (reg_wdata[KEY_LSB +: KEY_W]),
        .wbits (reg_wdata[N_ENG-1:0]),
        .cur   (req_q),
        .nxt   (req_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            cfg_q <= '0;
        end else begin
            if (wr_req) req_q <= req_d;
            if (wr_cfg) cfg_q <= reg_wdata[N_ENG-1:0];
        end
    end

    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        cg_gate_seq seq_i (
            .clk     (clk),
            .rst     (rst),
            .run_req (req_q[g]),
            .hs_mode (cfg_q[g]),
            .ack     (idle_ack[g]),
            .en      (clk_en[g]),
            .idle    (idle_req[g])
        );
    end

    cg_rd_mux #(.N_ENG(N_ENG), .DATA_W(DATA_W)) rd_i (
        .addr      (reg_addr),
        .req_bits  (req_q),
        .cfg_bits  (cfg_q),
        .stat_bits (clk_en),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/cg_req_ctrl_chk.sv
module cg_req_ctrl_chk
    import cg_req_pkg::*;
#(
    parameter int N_ENG  = 5,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_valid,
    input logic                  reg_write,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [N_ENG-1:0]      idle_ack,
    input logic [N_ENG-1:0]      clk_en,
    input logic [N_ENG-1:0]      idle_req,
    input logic [N_ENG-1:0]      req_q,
    input logic [N_ENG-1:0]      cfg_q
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    logic             wr0, wr1;
    logic [KEY_W-1:0] key;
    logic [N_ENG-1:0] wb;

    assign wr0 = reg_valid && reg_write && (reg_addr == 2'd0);
    assign wr1 = reg_valid && reg_write && (reg_addr == 2'd1);
    assign key = reg_wdata[KEY_LSB +: KEY_W];
    assign wb  = reg_wdata[N_ENG-1:0];

    AST_KEY_SET: assert property (@(posedge clk) disable iff (rst)
        wr0 && key == 4'h5 |=> req_q == ($past(req_q) | $past(wb))); // R2
    AST_KEY_CLR: assert property (@(posedge clk) disable iff (rst)
        wr0 && key == 4'h2 |=> req_q == ($past(req_q) & ~$past(wb))); // R3
    AST_KEY_PLAIN: assert property (@(posedge clk) disable iff (rst)
        wr0 && key != 4'h5 && key != 4'h2 |=> req_q == $past(wb)); // R4
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr1 |=> cfg_q == $past(wb)); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr0 |=> $stable(req_q)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr1 |=> $stable(cfg_q)); // R10

    for (genvar g = 0; g < N_ENG; g++) begin : g_eng_chk
        AST_UNGATE_NEXT: assert property (@(posedge clk) disable iff (rst)
            $rose(req_q[g]) |=> clk_en[g]); // R9
        AST_DIRECT_FALL: assert property (@(posedge clk) disable iff (rst)
            $fell(req_q[g]) && !cfg_q[g] && !idle_ack[g] |=> !clk_en[g]); // R7
        AST_HS_ACK_FIRST: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_en[g]) && $past(cfg_q[g]) |-> $past(idle_ack[g])); // R8
    end
endmodule

bind cg_req_ctrl cg_req_ctrl_chk #(.N_ENG(N_ENG), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .idle_ack  (idle_ack),
    .clk_en    (clk_en),
    .idle_req  (idle_req),
    .req_q     (req_q),
    .cfg_q     (cfg_q)
);

// File: tb/cg_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module cg_req_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_valid, reg_write;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [4:0]  idle_ack, clk_en, idle_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    cg_req_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .idle_ack(idle_ack), .clk_en(clk_en), .idle_req(idle_req)
    );

    // {key, data bits, expected request bits}, applied in order from request = 0
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {4'h0, 5'h15, 5'h15},  // R4 plain
        {4'h5, 5'h0A, 5'h1F},  // R2 set
        {4'h2, 5'h11, 5'h0E},  // R3 clear
        {4'h2, 5'h00, 5'h0E},  // R3 zero mask
        {4'h5, 5'h00, 5'h0E},  // R2 zero mask
        {4'h7, 5'h03, 5'h03},  // R4 other key
        {4'h5, 5'h10, 5'h13},  // R2 set top bit
        {4'h2, 5'h1F, 5'h00},  // R3 clear all
        {4'hF, 5'h1F, 5'h1F},  // R4 other key
        {4'h2, 5'h04, 5'h1B}   // R3 single bit
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic v, input logic w, input logic [1:0] a, input logic [31:0] d);
        reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0; idle_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 clk_en", {27'd0, clk_en}, 0);
        chk("R1 idle_req", {27'd0, idle_req}, 0);
        rd(2'd0, r); chk("R1 req read", r, 0);
        rd(2'd1, r); chk("R1 cfg read", r, 0);
        rd(2'd2, r); chk("R1 status read", r, 0);

        // key vectors, all engines in direct mode
        for (int i = 0; i < NV; i++) begin
            logic [3:0] k;
            logic [4:0] d, e;
            string tg;
            {k, d, e} = VEC[i];
            tg = (k == 4'h5) ? "R2" : (k == 4'h2) ? "R3" : "R4";
            acc(1, 1, 2'd0, {k, 23'h5A5A5, d});
            rd(2'd0, r); chk($sformatf("%s/R5 vec %0d req", tg, i), r, {27'd0, e});
            @(negedge clk);
            chk($sformatf("R7 vec %0d clk_en", i), {27'd0, clk_en}, {27'd0, e});
            chk($sformatf("R7 vec %0d idle_req", i), {27'd0, idle_req}, 0);
            rd(2'd2, r); chk($sformatf("R5 vec %0d status", i), r, {27'd0, e});
        end
        // request now 0x1B

        // R5 reserved address
        rd(2'd3, r); chk("R5 reserved read", r, 0);

        // R10 ignored accesses
        acc(0, 1, 2'd0, {4'h5, 28'h4});
        acc(1, 0, 2'd0, {4'h0, 28'h0});
        acc(1, 1, 2'd2, {4'h0, 28'h0});
        acc(1, 1, 2'd3, {4'h5, 28'h1F});
        rd(2'd0, r); chk("R10 req unchanged", r, 32'h1B);
        rd(2'd1, r); chk("R10 cfg unchanged", r, 0);

        // R8 handshake gate on engine 0
        acc(1, 1, 2'd1, 32'h0000_0001);
        rd(2'd1, r); chk("R6 cfg load", r, 32'h1);
        acc(1, 1, 2'd0, {4'h2, 28'h1});
        @(negedge clk);
        chk("R8 idle_req raised", {31'd0, idle_req[0]}, 1);
        chk("R8 clock still on", {31'd0, clk_en[0]}, 1);
        repeat (3) @(negedge clk);
        chk("R8 waits for ack", {31'd0, clk_en[0]}, 1);
        idle_ack[0] = 1'b1;
        @(negedge clk);
        chk("R8 gated after ack", {31'd0, clk_en[0]}, 0);
        chk("R8 idle_req held", {31'd0, idle_req[0]}, 1);
        rd(2'd2, r); chk("R5 status gated", r, 32'h1A);

        // R9 un-gate with ack still high
        acc(1, 1, 2'd0, {4'h5, 28'h1});
        @(negedge clk);
        chk("R9 clock back on", {31'd0, clk_en[0]}, 1);
        chk("R9 idle_req dropped", {31'd0, idle_req[0]}, 0);
        acc(1, 1, 2'd0, {4'h2, 28'h1});
        repeat (2) @(negedge clk);
        chk("R9 no new gate before ack low", {31'd0, idle_req[0]}, 0);
        chk("R9 clock kept on", {31'd0, clk_en[0]}, 1);
        idle_ack[0] = 1'b0;
        @(negedge clk);
        chk("R9 gate starts after ack low", {31'd0, idle_req[0]}, 1);
        chk("R7 direct engines untouched", {27'd0, clk_en[4:1], 1'b0}, 32'h1A);
        idle_ack[0] = 1'b1;
        @(negedge clk);
        chk("R8 second gate", {31'd0, clk_en[0]}, 0);

        // R6 key ignored on configuration write (plain load gives 0x02)
        acc(1, 1, 2'd1, {4'h5, 28'h2});
        rd(2'd1, r); chk("R6 key ignored on cfg", r, 32'h2);

        // R1 reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, r); chk("R1 req after reset", r, 0);
        chk("R1 clk_en after reset", {27'd0, clk_en}, 0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule